// File: doc/BRIEF.md
# Three-Channel Pin Event Timestamp Capture

This block records when chosen transitions happen on three external pins. Each pin passes through a two-flop synchronizer and then a qualifier. The qualifier accepts a new level only after that level has been seen on two consecutive clock edges, so one-cycle glitches are filtered out. A qualified transition that matches the channel's edge selection stores the value of an externally supplied 16-bit time base in that channel's two-entry FIFO. It also raises the channel's interrupt flag.

Software uses a small register port to work the block. It programs a control word, reads the FIFO fill state, flushes channels, masks interrupts, clears flags, and pops timestamps from three data ports. The register read path is combinational from `reg_addr_i`. A data-port read with `reg_rd_i` high pops that FIFO at the next clock edge. When a FIFO is full, a new capture drops the oldest entry, so each channel always keeps its two newest timestamps.

Register map (address on `reg_addr_i`): 0 control, 1 FIFO status, 2 interrupt mask, 3 interrupt flags, 4/5/6 capture data for channels 0/1/2. Any other address reads as zero.

Top module: `cap_unit`

## Requirements
- R1: After reset, the control, FIFO status, mask and flag registers all read 0x0000 and `irq_o` is low.
- R2: A pin change driven just before clock edge E1 is stored at edge E4. The status is unchanged after E3 and shows the entry after E4. A level that lasts only one clock cycle is never captured.
- R3: Control bits [5:4], [7:6] and [9:8] select the edge for channels 0, 1 and 2: 00 none, 01 rising, 10 falling, 11 both. A transition that is not selected stores nothing.
- R4: Control bit k enables channel k. A disabled channel stores nothing, whatever its edge selection.
- R5: Status bits [9:8], [11:10] and [13:12] report the fill state of channels 0, 1 and 2: 00 empty, 01 one entry, 10 two entries. Entries are read back oldest first.
- R6: A capture that arrives with two entries held sets the status to 11, discards the oldest entry and keeps the two newest values.
- R7: Reading data address 4+k returns channel k's oldest entry and removes it. Fill 01 becomes 00, and fill 10 or 11 becomes 01.
- R8: Reading an empty channel returns the last value it held and leaves its status at 00.
- R9: A capture sets flag bit k (address 3). Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. `irq_o` is high exactly when some flag bit is set together with its mask bit (address 2).
- R10: In the status register, the low byte always reads as zero. Writing 1 to bit k of the status register empties channel k.
- R11: A capture on one channel leaves the status and data of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 3 | Asynchronous capture pins, bit k for channel k |
| tbase_i | input | 16 | Free-running time base value to be captured |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Read strobe; pops a FIFO when addressing a data port |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request, OR of flags masked by enables |

## Verification
The bench measures the exact edge at which a pin change first shows in the status register. A qualifier that is one stage short or one stage long would move that edge and fail the check. It drives a one-cycle pulse that a design without qualification would timestamp. It fills a FIFO three times and checks that the two newest values are kept; a design that dropped the newest value, or stalled at status 10, would return the wrong timestamps. It also reads an empty FIFO, clears flags with both 0 and 1 written, and flushes through the write-only status byte. A design that let an empty read wrap the count, cleared flags on writing 0, or gated the interrupt without the mask would each give a wrong readback.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int NCH_DEF = 3;
    localparam int TW_DEF  = 16;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'b00,
        FILL_ONE   = 2'b01,
        FILL_TWO   = 2'b10,
        FILL_OVER  = 2'b11
    } fill_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic logic edge_hit(edge_sel_e sel, edge_ev_t ev);
        return (sel[0] & ev.rise) | (sel[1] & ev.fall);
    endfunction

endpackage

// File: rtl/cap_pin_qual.sv
module cap_pin_qual
    import cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_i,
    output edge_ev_t ev_o
);
    localparam int SMSB = SYNC_STAGES - 1;

    logic [SMSB:0] sync_q;
    logic          hold_q;
    logic          lvl_q;
    logic          settle;

    // new level seen on two consecutive edges and differing from accepted level
    assign settle = (sync_q[SMSB] == hold_q) && (hold_q != lvl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hold_q <= 1'b0;
            lvl_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SMSB-1:0], pin_i};
            hold_q <= sync_q[SMSB];
            if (settle) lvl_q <= hold_q;
        end
    end

    always_comb begin
        ev_o.rise = settle & hold_q;
        ev_o.fall = settle & ~hold_q;
    end

endmodule

// File: rtl/cap_fifo2.sv
module cap_fifo2
    import cap_pkg::*;
#(
    parameter int TW = TW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          flush_i,
    input  logic [TW-1:0] din_i,
    output logic [TW-1:0] head_o,
    output logic [1:0]    fill_o
);
    logic [TW-1:0] old_q, new_q;
    fill_e         fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            old_q  <= '0;
            new_q  <= '0;
            fill_q <= FILL_EMPTY;
        end else if (flush_i) begin
            fill_q <= FILL_EMPTY;
        end else begin
            unique case ({push_i, pop_i})
                2'b10: begin
                    unique case (fill_q)
                        FILL_EMPTY: begin old_q <= din_i; fill_q <= FILL_ONE; end
                        FILL_ONE:   begin new_q <= din_i; fill_q <= FILL_TWO; end
                        default:    begin old_q <= new_q; new_q <= din_i; fill_q <= FILL_OVER; end
                    endcase
                end
                2'b01: begin
                    unique case (fill_q)
                        FILL_EMPTY: ;
                        FILL_ONE:   fill_q <= FILL_EMPTY;
                        default:    begin old_q <= new_q; fill_q <= FILL_ONE; end
                    endcase
                end
                2'b11: begin
                    unique case (fill_q)
                        FILL_EMPTY: begin old_q <= din_i; fill_q <= FILL_ONE; end
                        FILL_ONE:   old_q <= din_i;
                        default:    begin old_q <= new_q; new_q <= din_i; fill_q <= FILL_TWO; end
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign head_o = old_q;
    assign fill_o = fill_q;

endmodule

// File: rtl/cap_unit.sv
module cap_unit
    import cap_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int TW  = TW_DEF,
    parameter int RW  = 16,
    parameter int AW  = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pin_i,
    input  logic [TW-1:0]  tbase_i,
    input  logic [AW-1:0]  reg_addr_i,
    input  logic           reg_wr_i,
    input  logic           reg_rd_i,
    input  logic [RW-1:0]  reg_wdata_i,
    output logic [RW-1:0]  reg_rdata_o,
    output logic           irq_o
);
    localparam int EDGE_LSB = 4;
    localparam int STAT_LSB = 8;
    localparam logic [AW-1:0] A_CTRL  = AW'(0);
    localparam logic [AW-1:0] A_STAT  = AW'(1);
    localparam logic [AW-1:0] A_MASK  = AW'(2);
    localparam logic [AW-1:0] A_FLAG  = AW'(3);
    localparam logic [AW-1:0] A_DATA0 = AW'(4);

    logic [RW-1:0]           ctrl_q;
    logic [NCH-1:0]          mask_q;
    logic [NCH-1:0]          flag_q;
    logic [NCH-1:0]          push, pop, flush;
    logic [NCH-1:0][1:0]     fill_st;
    logic [NCH-1:0][TW-1:0]  head;
    logic [NCH-1:0]          flag_clr;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        localparam logic [AW-1:0] A_DK = A_DATA0 + AW'(k);
        edge_ev_t  ev;
        edge_sel_e sel;

        cap_pin_qual #(.SYNC_STAGES(2)) qual_i (
            .clk   (clk),
            .rst   (rst),
            .pin_i (pin_i[k]),
            .ev_o  (ev)
        );

        assign sel      = edge_sel_e'(ctrl_q[EDGE_LSB + 2*k +: 2]);
        assign push[k]  = ctrl_q[k] & edge_hit(sel, ev);
        assign pop[k]   = reg_rd_i && (reg_addr_i == A_DK);
        assign flush[k] = reg_wr_i && (reg_addr_i == A_STAT) && reg_wdata_i[k];

        cap_fifo2 #(.TW(TW)) fifo_i (
            .clk     (clk),
            .rst     (rst),
            .push_i  (push[k]),
            .pop_i   (pop[k]),
            .flush_i (flush[k]),
            .din_i   (tbase_i),
            .head_o  (head[k]),
            .fill_o  (fill_st[k])
        );
    end

    assign flag_clr = (reg_wr_i && reg_addr_i == A_FLAG) ? reg_wdata_i[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
            flag_q <= '0;
        end else begin
            if (reg_wr_i && reg_addr_i == A_CTRL) ctrl_q <= reg_wdata_i;
            if (reg_wr_i && reg_addr_i == A_MASK) mask_q <= reg_wdata_i[NCH-1:0];
            flag_q <= (flag_q & ~flag_clr) | push;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == A_CTRL) reg_rdata_o = ctrl_q;
        if (reg_addr_i == A_MASK) reg_rdata_o[NCH-1:0] = mask_q;
        if (reg_addr_i == A_FLAG) reg_rdata_o[NCH-1:0] = flag_q;
        for (int k = 0; k < NCH; k++) begin
            if (reg_addr_i == A_STAT) reg_rdata_o[STAT_LSB + 2*k +: 2] = fill_st[k];
            if (reg_addr_i == A_DATA0 + AW'(k)) reg_rdata_o[TW-1:0] = head[k];
        end
    end

    assign irq_o = |(flag_q & mask_q);

endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
    parameter int NCH = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                irq_o,
    input logic [NCH-1:0]      flag_q,
    input logic [NCH-1:0]      mask_q,
    input logic [NCH-1:0]      push,
    input logic [NCH-1:0]      pop,
    input logic [NCH-1:0]      flush,
    input logic [NCH-1:0][1:0] fill_st
);
    a_r1_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        ((flag_q & mask_q) == '0) |-> !irq_o);

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        a_r5_first_entry: assert property (@(posedge clk) disable iff (rst)
            (fill_st[k] == 2'd0 && push[k] && !pop[k] && !flush[k]) |=> fill_st[k] == 2'd1);
        a_r6_over_holds: assert property (@(posedge clk) disable iff (rst)
            (fill_st[k] == 2'd3 && !pop[k] && !flush[k]) |=> fill_st[k] == 2'd3);
        a_r7_pop_full: assert property (@(posedge clk) disable iff (rst)
            (fill_st[k] == 2'd2 && pop[k] && !push[k] && !flush[k]) |=> fill_st[k] == 2'd1);
        a_r8_empty_read: assert property (@(posedge clk) disable iff (rst)
            (fill_st[k] == 2'd0 && pop[k] && !push[k] && !flush[k]) |=> fill_st[k] == 2'd0);
        a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
            push[k] |=> flag_q[k]);
        a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
            flush[k] |=> fill_st[k] == 2'd0);
    end

endmodule

bind cap_unit cap_unit_chk #(.NCH(NCH)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .irq_o   (irq_o),
    .flag_q  (flag_q),
    .mask_q  (mask_q),
    .push    (push),
    .pop     (pop),
    .flush   (flush),
    .fill_st (fill_st)
);

// File: tb/cap_unit_tb_top.sv
`timescale 1ns/1ps
module cap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  pins = '0;
    logic [15:0] tbase = '0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_MASK = 3'd2, A_FLAG = 3'd3;

    always #10 clk = ~clk;

    cap_unit dut_i (
        .clk (clk), .rst (rst), .pin_i (pins), .tbase_i (tbase),
        .reg_addr_i (addr), .reg_wr_i (wr), .reg_rd_i (rd),
        .reg_wdata_i (wdata), .reg_rdata_o (rdata), .irq_o (irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] v);
        addr = a; #1 v = rdata;
    endtask

    task automatic pin_to(input int ch, input logic val, input logic [15:0] tb);
        @(negedge clk); tbase = tb; pins[ch] = val;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(A_CTRL, v); chk("R1 ctrl", v, 16'h0000);
        peek(A_STAT, v); chk("R1 status", v, 16'h0000);
        peek(A_MASK, v); chk("R1 mask", v, 16'h0000);
        peek(A_FLAG, v); chk("R1 flags", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_latency();
        logic [15:0] v;
        do_wr(A_CTRL, 16'h0011);
        do_wr(A_MASK, 16'h0001);
        @(negedge clk); tbase = 16'h1234; pins[0] = 1'b1;
        repeat (3) @(negedge clk);
        peek(A_STAT, v); chk("R2 no entry after third edge", v, 16'h0000);
        @(negedge clk);
        peek(A_STAT, v); chk("R2 entry after fourth edge", v, 16'h0100);
        peek(A_FLAG, v); chk("R9 flag set on capture", v, 16'h0001);
        chk("R9 irq with mask", {15'd0, irq}, 16'h0001);
        do_rd(3'd4, v); chk("R7 data ch0", v, 16'h1234);
        peek(A_STAT, v); chk("R7 status after pop", v, 16'h0000);
    endtask

    task automatic t_glitch();
        logic [15:0] v;
        pin_to(0, 1'b0, 16'h2000);
        peek(A_STAT, v); chk("R3 falling not selected", v, 16'h0000);
        @(negedge clk); tbase = 16'h2001; pins[0] = 1'b1;
        @(negedge clk); pins[0] = 1'b0;
        repeat (6) @(negedge clk);
        peek(A_STAT, v); chk("R2 one-cycle pulse ignored", v, 16'h0000);
        do_wr(A_FLAG, 16'h0000);
        peek(A_FLAG, v); chk("R9 write 0 keeps flag", v, 16'h0001);
        do_wr(A_FLAG, 16'h0001);
        peek(A_FLAG, v); chk("R9 write 1 clears flag", v, 16'h0000);
        chk("R9 irq low after clear", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_edges();
        logic [15:0] v;
        do_wr(A_CTRL, 16'h0397);
        pin_to(1, 1'b1, 16'h0A00);
        peek(A_STAT, v); chk("R3 rising ignored on falling ch1", v, 16'h0000);
        pin_to(1, 1'b0, 16'h0B00);
        peek(A_STAT, v); chk("R3 falling captured ch1", v, 16'h0400);
        pin_to(2, 1'b1, 16'h0C01);
        pin_to(2, 1'b0, 16'h0C02);
        peek(A_STAT, v); chk("R5 ch2 two entries, R11 others intact", v, 16'h2400);
        do_rd(3'd5, v); chk("R3 ch1 data", v, 16'h0B00);
        do_rd(3'd6, v); chk("R5 ch2 oldest first", v, 16'h0C01);
        peek(A_STAT, v); chk("R7 ch2 two to one", v, 16'h1000);
        do_rd(3'd6, v); chk("R5 ch2 second entry", v, 16'h0C02);
        peek(A_STAT, v); chk("R11 all empty", v, 16'h0000);
    endtask

    task automatic t_disable();
        logic [15:0] v;
        do_wr(A_CTRL, 16'h0010);
        pin_to(0, 1'b1, 16'h3000);
        peek(A_STAT, v); chk("R4 disabled channel no capture", v, 16'h0000);
    endtask

    task automatic t_overflow();
        logic [15:0] v;
        do_wr(A_CTRL, 16'h0031);
        pin_to(0, 1'b0, 16'h0101);
        pin_to(0, 1'b1, 16'h0102);
        peek(A_STAT, v); chk("R5 two entries", v, 16'h0200);
        pin_to(0, 1'b0, 16'h0103);
        peek(A_STAT, v); chk("R6 overflow status", v, 16'h0300);
        do_rd(3'd4, v); chk("R6 oldest dropped", v, 16'h0102);
        peek(A_STAT, v); chk("R7 over to one", v, 16'h0100);
        do_rd(3'd4, v); chk("R6 newest kept", v, 16'h0103);
        do_rd(3'd4, v); chk("R8 empty read last value", v, 16'h0103);
        peek(A_STAT, v); chk("R8 status stays empty", v, 16'h0000);
    endtask

    task automatic t_flush_mask();
        logic [15:0] v;
        do_wr(A_FLAG, 16'h0007);
        do_wr(A_MASK, 16'h0000);
        pin_to(0, 1'b1, 16'h0201);
        pin_to(0, 1'b0, 16'h0202);
        peek(A_STAT, v); chk("R10 low byte reads zero", v, 16'h0200);
        chk("R9 masked flag no irq", {15'd0, irq}, 16'h0000);
        do_wr(A_MASK, 16'h0001);
        chk("R9 unmasked irq", {15'd0, irq}, 16'h0001);
        do_wr(A_STAT, 16'h0001);
        peek(A_STAT, v); chk("R10 flush empties ch0", v, 16'h0000);
        do_wr(A_FLAG, 16'h0001);
        chk("R9 irq drops after clear", {15'd0, irq}, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_glitch();
        t_edges();
        t_disable();
        t_overflow();
        t_flush_mask();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule